// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block serves one serial channel. It walks a circular ring of two-word transmit descriptors that the host keeps in memory. It collects the buffers of each chained frame into a byte stream with start and end markers. It hands every descriptor back to the host by writing its first word to zero, and then raises a transmit event. All descriptor reads, buffer reads and ownership write-backs go over one simple request/acknowledge memory master port.

Software, or a neighbouring block, sets the ring bounds with `ring_start`/`ring_end` and pulses `ring_load` to move the current pointer to the ring start. Each `scan_go` pulse then starts one scan pass. The pass sends frames until it meets a descriptor the host does not own, or until it has sent a fixed number of frames. A `mode` input picks one of two conventions. They differ in how the length field is read and in when the ring pointer wraps.

The FSM states are:

| State | Role |
|---|---|
| `ST_IDLE` | Waits for a pass to start. |
| `ST_HEAD` | Reads word 0 of a descriptor. |
| `ST_ADDR` | Reads word 1 of a descriptor. |
| `ST_DATA` | Reads one buffer byte per memory access. |
| `ST_RETIRE` | Zeroes word 0 of a descriptor that is not first-segment. |
| `ST_NEXT` | Advances the ring pointer. |
| `ST_PAD` | Emits the trailing pad bytes. |
| `ST_CLOSE` | Ends the frame on the stream. |
| `ST_RELEASE` | Zeroes word 0 of the frame's first descriptor. |
| `ST_NOTIFY` | Raises the event and counts the frame. |
| `ST_ABORT` | Ends a broken frame with an error marker. |

The transitions are:

- IDLE→HEAD on a start.
- HEAD→ADDR when the descriptor is owned.
- HEAD→IDLE when the first descriptor of a frame is not owned.
- HEAD→ABORT when a descriptor in the middle of a chain is not owned.
- ADDR→DATA when the buffer length is nonzero.
- ADDR→RETIRE when the buffer length is zero.
- DATA→RETIRE after the last byte of the buffer.
- RETIRE→NEXT.
- NEXT→HEAD when more segments follow.
- NEXT→PAD on a last segment.
- PAD→CLOSE.
- CLOSE→RELEASE.
- RELEASE→NOTIFY.
- NOTIFY→HEAD, or NOTIFY→IDLE when the frame limit is reached.
- ABORT→IDLE.

Top module: `txring_reader`

## Requirements
- R1: Descriptor word 0 uses these fields: bit 31 means the host handed the descriptor over, bit 30 marks the first segment, bit 29 marks the last segment, and bits [11:0] hold the length. Word 1 holds the buffer byte address. A pass whose current descriptor has bit 31 clear ends with no write to memory, no stream output and no event.
- R2: When `mode`=0, the buffer byte count equals bits [11:0].
- R3: When `mode`=1, the buffer byte count is bits [11:0] times 4. If bit 20 is set, the value in bits [25:24] is subtracted from that product, and the result is floored at zero.
- R4: A buffer of zero length is skipped without any memory read at its address.
- R5: Word 0 of a descriptor with bit 30 clear is written to zero as soon as its buffer has been read. Word 0 of the frame's first descriptor is zeroed only after the frame's last byte has left the stream.
- R6: When a frame has a nonzero byte total, ((p−1) AND 3) zero bytes are appended to it, where p is bits [23:22] of the last descriptor. A frame with a zero total gets no pad bytes.
- R7: Each frame with bytes appears on the stream with `out_sof` on its first byte and `out_eof` on its last byte. Buffer bytes appear in address order, and byte lane k of a memory word holds the byte at address offset k.
- R8: If a descriptor after the first of a chain does not have bit 31 set, the frame ends with `out_eof` and `out_err` set on its last emitted byte. The first descriptor is not released, no event is raised, and the pass ends.
- R9: The ring step is 8 bytes. In mode 0 the pointer is stepped first and becomes `ring_start` if it then equals `ring_end`. In mode 1 the pointer becomes `ring_start` if it already equals `ring_end`, and is stepped otherwise.
- R10: One pass sends at most 16 frames. A new `scan_go` continues from where the pass stopped.
- R11: Every completed frame, including one with a zero byte total, gives a one-cycle `irq_req` pulse and sets `tx_flag`. The flag stays set until `flag_clr` is pulsed.
- R12: A frame delivers at most 2048 bytes, counting pad bytes. Bytes beyond that limit are dropped, and the frame still ends with `out_eof`.
- R13: A `scan_go` is ignored while `chan_en` is low or while `ring_start` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 1 | Length and wrap convention |
| chan_en | input | 1 | Channel enable |
| ring_start | input | 32 | Ring base byte address |
| ring_end | input | 32 | Ring end byte address |
| ring_load | input | 1 | Moves the current pointer to `ring_start` |
| scan_go | input | 1 | Starts one scan pass |
| flag_clr | input | 1 | Clears `tx_flag` |
| busy | output | 1 | A pass is in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned for descriptors |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed |
| out_valid | output | 1 | Stream byte valid |
| out_byte | output | 8 | Stream byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_err | output | 1 | Frame broken, qualified by `out_eof` |
| tx_flag | output | 1 | Sticky transmit event flag |
| irq_req | output | 1 | One-cycle interrupt request per frame |

## Verification
The assertions check on every cycle:
- a memory request holds its address until it is acknowledged;
- every write carries zero;
- the first descriptor is released only after the stream stage has emptied;
- the data state is never entered with zero bytes to fetch;
- a frame never starts inside another frame;
- the byte limit and the per-pass frame limit are never exceeded.

Only the bench scenarios can show that the right values result:
- the lengths decoded under each mode, including subtraction and pad;
- the byte order taken from unaligned buffers;
- the different wrap points of the two modes;
- the release pattern in host memory after a chain or an abort;
- the way a pass resumes after the frame limit.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int OWN_BIT  = 31;
    localparam int FIRST_BIT = 30;
    localparam int LAST_BIT = 29;
    localparam int SUBEN_BIT = 20;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD,
        ST_ADDR,
        ST_DATA,
        ST_RETIRE,
        ST_NEXT,
        ST_PAD,
        ST_CLOSE,
        ST_RELEASE,
        ST_NOTIFY,
        ST_ABORT
    } txr_state_e;
endpackage

// File: rtl/txr_len_calc.sv
module txr_len_calc #(
    parameter int LEN_W = 14
) (
    input  logic             mode,
    input  logic [31:0]      w0,
    output logic [LEN_W-1:0] blen,
    output logic [1:0]       pad_add
);
    import txr_pkg::*;

    logic [LEN_W-1:0] raw;
    logic [LEN_W-1:0] quad;
    logic [LEN_W-1:0] sub;

    always_comb begin
        raw  = LEN_W'(w0[11:0]);
        quad = LEN_W'({w0[11:0], 2'b00});
        sub  = w0[SUBEN_BIT] ? LEN_W'(w0[25:24]) : '0;
        if (!mode) begin
            blen = raw;
        end else if (quad < sub) begin
            blen = '0;
        end else begin
            blen = quad - sub;
        end
        // 2-bit wrap gives (p - 1) AND 3
        pad_add = w0[23:22] - 2'd1;
    end
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] end_addr,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] stepped;
    logic [AW-1:0] nxt;

    always_comb begin
        stepped = cur + AW'(STEP);
        if (!mode) begin
            nxt = (stepped == end_addr) ? start_addr : stepped;
        end else begin
            nxt = (cur == end_addr) ? start_addr : stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= start_addr;
        end else if (adv) begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/txr_byte_out.sv
module txr_byte_out #(
    parameter int MAX_BYTES = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       flush,
    input  logic       flush_err,
    output logic       held,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_sof,
    output logic       out_eof,
    output logic       out_err
);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    logic [7:0]       hold_q;
    logic             sof_pend;
    logic [CNT_W-1:0] cnt;
    logic             in_frm;
    logic             take;

    assign take = push && (cnt < CNT_W'(MAX_BYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held      <= 1'b0;
            hold_q    <= '0;
            sof_pend  <= 1'b1;
            cnt       <= '0;
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_err   <= 1'b0;
            if (take) begin
                cnt    <= cnt + 1'b1;
                hold_q <= push_byte;
                held   <= 1'b1;
                if (held) begin
                    out_valid <= 1'b1;
                    out_byte  <= hold_q;
                    out_sof   <= sof_pend;
                    sof_pend  <= 1'b0;
                end
            end else if (flush) begin
                cnt      <= '0;
                held     <= 1'b0;
                sof_pend <= 1'b1;
                if (held) begin
                    out_valid <= 1'b1;
                    out_byte  <= hold_q;
                    out_sof   <= sof_pend;
                    out_eof   <= 1'b1;
                    out_err   <= flush_err;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_frm <= 1'b0;
        end else if (out_valid) begin
            in_frm <= !out_eof;
        end
    end

    // R7
    sof_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> !in_frm);

    // R12
    byte_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/txring_reader.sv
module txring_reader #(
    parameter int AW         = 32,
    parameter int MAX_FRAMES = 16,
    parameter int MAX_BYTES  = 2048,
    parameter int DESC_STEP  = 8,
    parameter int LEN_W      = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          chan_en,
    input  logic [AW-1:0] ring_start,
    input  logic [AW-1:0] ring_end,
    input  logic          ring_load,
    input  logic          scan_go,
    input  logic          flag_clr,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          out_valid,
    output logic [7:0]    out_byte,
    output logic          out_sof,
    output logic          out_eof,
    output logic          out_err,
    output logic          tx_flag,
    output logic          irq_req
);
    import txr_pkg::*;

    localparam int FC_W = $clog2(MAX_FRAMES + 1);

    txr_state_e       state;
    logic [31:0]      w0_q;
    logic [AW-1:0]    buf_addr;
    logic [LEN_W-1:0] left;
    logic [AW-1:0]    first_addr;
    logic             mid;
    logic             any_bytes;
    logic [1:0]       pad_left;
    logic [FC_W-1:0]  frame_cnt;

    logic [AW-1:0]    cur;
    logic             adv;
    logic [LEN_W-1:0] blen;
    logic [1:0]       pad_add;
    logic             push;
    logic [7:0]       push_byte;
    logic             flush;
    logic             flush_err;
    logic             held;
    logic             start_ok;

    assign start_ok = scan_go && chan_en && (ring_start != '0);

    txr_len_calc #(.LEN_W(LEN_W)) u_len (
        .mode    (mode),
        .w0      (w0_q),
        .blen    (blen),
        .pad_add (pad_add)
    );

    txr_ring_ptr #(.AW(AW), .STEP(DESC_STEP)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .load       (ring_load),
        .adv        (adv),
        .start_addr (ring_start),
        .end_addr   (ring_end),
        .cur        (cur)
    );

    txr_byte_out #(.MAX_BYTES(MAX_BYTES)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_byte (push_byte),
        .flush     (flush),
        .flush_err (flush_err),
        .held      (held),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_err   (out_err)
    );

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            w0_q       <= '0;
            buf_addr   <= '0;
            left       <= '0;
            first_addr <= '0;
            mid        <= 1'b0;
            any_bytes  <= 1'b0;
            pad_left   <= '0;
            frame_cnt  <= '0;
            tx_flag    <= 1'b0;
            irq_req    <= 1'b0;
        end else begin
            irq_req <= 1'b0;
            if (state == ST_NOTIFY) begin
                tx_flag <= 1'b1;
                irq_req <= 1'b1;
            end else if (flag_clr) begin
                tx_flag <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        first_addr <= cur;
                        mid        <= 1'b0;
                        any_bytes  <= 1'b0;
                        frame_cnt  <= '0;
                        state      <= ST_HEAD;
                    end
                end
                ST_HEAD: begin
                    if (mem_ack) begin
                        w0_q <= mem_rdata;
                        if (!mem_rdata[OWN_BIT]) begin
                            state <= mid ? ST_ABORT : ST_IDLE;
                        end else begin
                            state <= ST_ADDR;
                        end
                    end
                end
                ST_ADDR: begin
                    if (mem_ack) begin
                        buf_addr <= mem_rdata[AW-1:0];
                        left     <= blen;
                        if (blen != '0) begin
                            any_bytes <= 1'b1;
                        end
                        if (w0_q[LAST_BIT]) begin
                            pad_left <= (any_bytes || blen != '0) ? pad_add : 2'd0;
                        end
                        state <= (blen == '0) ? ST_RETIRE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (mem_ack) begin
                        buf_addr <= buf_addr + 1'b1;
                        left     <= left - 1'b1;
                        if (left == LEN_W'(1)) begin
                            state <= ST_RETIRE;
                        end
                    end
                end
                ST_RETIRE: begin
                    if (w0_q[FIRST_BIT] || mem_ack) begin
                        state <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    mid   <= 1'b1;
                    state <= w0_q[LAST_BIT] ? ST_PAD : ST_HEAD;
                end
                ST_PAD: begin
                    if (pad_left == 2'd0) begin
                        state <= ST_CLOSE;
                    end else begin
                        pad_left <= pad_left - 1'b1;
                    end
                end
                ST_CLOSE: begin
                    state <= ST_RELEASE;
                end
                ST_RELEASE: begin
                    if (mem_ack) begin
                        state <= ST_NOTIFY;
                    end
                end
                ST_NOTIFY: begin
                    frame_cnt  <= frame_cnt + 1'b1;
                    first_addr <= cur;
                    mid        <= 1'b0;
                    any_bytes  <= 1'b0;
                    if (frame_cnt == FC_W'(MAX_FRAMES - 1)) begin
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_HEAD;
                    end
                end
                ST_ABORT: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_wdata = '0;
        adv       = 1'b0;
        push      = 1'b0;
        push_byte = '0;
        flush     = 1'b0;
        flush_err = 1'b0;
        busy      = (state != ST_IDLE);
        unique case (state)
            ST_HEAD: begin
                mem_req  = 1'b1;
                mem_addr = cur;
            end
            ST_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = cur + AW'(4);
            end
            ST_DATA: begin
                mem_req   = 1'b1;
                mem_addr  = {buf_addr[AW-1:2], 2'b00};
                push      = mem_ack;
                push_byte = mem_rdata[8*buf_addr[1:0] +: 8];
            end
            ST_RETIRE: begin
                mem_req  = !w0_q[FIRST_BIT];
                mem_we   = !w0_q[FIRST_BIT];
                mem_addr = cur;
            end
            ST_NEXT: begin
                adv = 1'b1;
            end
            ST_PAD: begin
                push = (pad_left != 2'd0);
            end
            ST_CLOSE: begin
                flush = 1'b1;
            end
            ST_RELEASE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = first_addr;
            end
            ST_ABORT: begin
                flush     = 1'b1;
                flush_err = 1'b1;
            end
            default: ;
        endcase
    end

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R5
    write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && mem_wdata == 32'd0));

    // R5
    release_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE) |-> !held);

    // R4
    no_empty_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (left != '0));

    // R10
    frame_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= FC_W'(MAX_FRAMES));

    // R11
    irq_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> tx_flag);
endmodule

// File: tb/txring_reader_test.sv
module txring_reader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        chan_en = 1'b0;
    logic [31:0] ring_start = '0;
    logic [31:0] ring_end = '0;
    logic        ring_load = 1'b0;
    logic        scan_go = 1'b0;
    logic        flag_clr = 1'b0;
    logic        busy;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        out_valid, out_sof, out_eof, out_err;
    logic [7:0]  out_byte;
    logic        tx_flag, irq_req;

    always #5 clk = ~clk;

    txring_reader uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .chan_en(chan_en),
        .ring_start(ring_start), .ring_end(ring_end), .ring_load(ring_load),
        .scan_go(scan_go), .flag_clr(flag_clr), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .out_valid(out_valid), .out_byte(out_byte), .out_sof(out_sof),
        .out_eof(out_eof), .out_err(out_err), .tx_flag(tx_flag), .irq_req(irq_req)
    );

    logic [31:0] mem [0:1023];
    int oob_n = 0;
    int wr_n = 0;

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_addr >= 32'h1000) begin
                oob_n <= oob_n + 1;
                mem_rdata <= '0;
            end else if (mem_we) begin
                mem[mem_addr[11:2]] <= mem_wdata;
                wr_n <= wr_n + 1;
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    logic [7:0] cap [0:4095];
    int cap_n = 0, sof_n = 0, eof_n = 0, err_n = 0, irq_n = 0;

    always @(negedge clk) begin
        if (out_valid) begin
            if (cap_n < 4096) cap[cap_n] <= out_byte;
            cap_n <= cap_n + 1;
            if (out_sof) sof_n <= sof_n + 1;
            if (out_eof) eof_n <= eof_n + 1;
            if (out_eof && out_err) err_n <= err_n + 1;
        end
        if (irq_req) irq_n <= irq_n + 1;
    end

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog expired act=%0d exp<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int a);
        logic [31:0] av;
        av = a;
        return av[7:0] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 1024; i++)
            mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    endtask

    task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] w1);
        mem[a >> 2] = w0;
        mem[(a >> 2) + 1] = w1;
    endtask

    task automatic clear_caps();
        @(negedge clk);
        cap_n = 0; sof_n = 0; eof_n = 0; err_n = 0; irq_n = 0; oob_n = 0; wr_n = 0;
    endtask

    task automatic set_ring(input logic [31:0] s, input logic [31:0] e);
        @(negedge clk);
        ring_start = s; ring_end = e; ring_load = 1'b1;
        @(negedge clk);
        ring_load = 1'b0;
    endtask

    task automatic run_pass();
        @(negedge clk);
        scan_go = 1'b1;
        @(negedge clk);
        scan_go = 1'b0;
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // mode, w0, data bytes, expected frame length
    localparam logic [64:0] VEC [6] = '{
        {1'b0, 32'hE040_0005, 16'd5, 16'd5},
        {1'b0, 32'hE000_0005, 16'd5, 16'd8},
        {1'b0, 32'hE0C0_0007, 16'd7, 16'd9},
        {1'b1, 32'hE040_0003, 16'd12, 16'd12},
        {1'b1, 32'hE350_0003, 16'd9, 16'd9},
        {1'b1, 32'hE190_0002, 16'd7, 16'd8}
    };

    initial begin
        fill_mem();
        chan_en = 1'b1;
        repeat (3) @(negedge clk);
        // reset state
        chk(busy == 0 && mem_req == 0, "reset R1 idle", {busy, mem_req}, 0);
        chk(out_valid == 0, "reset R7 stream quiet", out_valid, 0);
        chk(tx_flag == 0 && irq_req == 0, "reset R11 flag", {tx_flag, irq_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table: single-descriptor frames, R2 R3 R6 R7
        for (int v = 0; v < 6; v++) begin
            logic [64:0] e;
            int dl, el;
            bit okb;
            e = VEC[v];
            dl = int'(e[31:16]);
            el = int'(e[15:0]);
            mode = e[64];
            put_desc(32'h100, e[63:32], 32'h401);
            set_ring(32'h100, 32'h200);
            clear_caps();
            run_pass();
            chk(cap_n == el, $sformatf("R2/R3/R6 vec%0d length", v), cap_n, el);
            okb = 1;
            for (int i = 0; i < el; i++) begin
                if (i < dl) begin
                    if (cap[i] != pat(32'h401 + i)) okb = 0;
                end else if (cap[i] != 8'h00) okb = 0;
            end
            chk(okb, $sformatf("R7 vec%0d bytes", v), okb, 1);
            chk(sof_n == 1 && eof_n == 1, $sformatf("R7 vec%0d markers", v), {sof_n, eof_n}, 1 << 32 | 1);
            chk(mem[32'h100 >> 2] == 0, $sformatf("R5 vec%0d release", v), mem[32'h100 >> 2], 0);
            chk(irq_n == 1, $sformatf("R11 vec%0d irq", v), irq_n, 1);
        end

        // chain with zero-length middle buffer: R4 R5 R7
        mode = 1'b0;
        put_desc(32'h100, 32'hC000_0003, 32'h400);
        put_desc(32'h108, 32'h8000_0000, 32'h2000);
        put_desc(32'h110, 32'hA040_0002, 32'h410);
        set_ring(32'h100, 32'h200);
        clear_caps();
        run_pass();
        chk(cap_n == 5, "R7 chain length", cap_n, 5);
        chk(cap[0] == pat(32'h400) && cap[2] == pat(32'h402) && cap[3] == pat(32'h410)
            && cap[4] == pat(32'h411), "R7 chain order", cap[3], pat(32'h410));
        chk(oob_n == 0, "R4 zero buffer not read", oob_n, 0);
        chk(mem[32'h108 >> 2] == 0 && mem[32'h110 >> 2] == 0, "R5 segments released",
            mem[32'h110 >> 2], 0);
        chk(mem[32'h100 >> 2] == 0 && eof_n == 1 && irq_n == 1, "R5 first released", mem[32'h100 >> 2], 0);

        // mid-chain abort: R8
        put_desc(32'h100, 32'hC000_0002, 32'h400);
        put_desc(32'h108, 32'h2000_0001, 32'h400);
        set_ring(32'h100, 32'h200);
        clear_caps();
        run_pass();
        chk(eof_n == 1 && err_n == 1, "R8 error end", err_n, 1);
        chk(cap_n == 2, "R8 bytes before abort", cap_n, 2);
        chk(mem[32'h100 >> 2] == 32'hC000_0002, "R8 first kept", mem[32'h100 >> 2], 32'hC000_0002);
        chk(irq_n == 0 && busy == 0, "R8 no event", irq_n, 0);

        // zero total frame: R4 R6 R11
        put_desc(32'h100, 32'hE000_0000, 32'h2000);
        set_ring(32'h100, 32'h200);
        clear_caps();
        run_pass();
        chk(cap_n == 0 && oob_n == 0, "R6 zero total no pad", cap_n, 0);
        chk(irq_n == 1 && mem[32'h100 >> 2] == 0, "R11 zero total event", irq_n, 1);

        // non-owned start: R1
        put_desc(32'h100, 32'h6000_0004, 32'h400);
        set_ring(32'h100, 32'h200);
        clear_caps();
        run_pass();
        chk(wr_n == 0 && cap_n == 0 && irq_n == 0, "R1 not owned idle", wr_n + cap_n + irq_n, 0);
        chk(mem[32'h100 >> 2] == 32'h6000_0004, "R1 desc intact", mem[32'h100 >> 2], 32'h6000_0004);

        // wrap, mode 0 vs mode 1: R9
        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            for (int k = 0; k < 4; k++) put_desc(32'h100 + 8*k, 32'hE040_0001, 32'h400);
            set_ring(32'h100, 32'h118);
            clear_caps();
            run_pass();
            chk(eof_n == 3 + m, $sformatf("R9 mode%0d frames", m), eof_n, 3 + m);
            chk(mem[32'h118 >> 2] == (m ? 32'h0 : 32'hE040_0001), $sformatf("R9 mode%0d last slot", m),
                mem[32'h118 >> 2], m ? 0 : 32'hE040_0001);
        end

        // pass limit: R10
        mode = 1'b0;
        for (int k = 0; k < 32; k++)
            put_desc(32'h100 + 8*k, (k < 20) ? 32'hE040_0001 : 32'h0, 32'h400);
        set_ring(32'h100, 32'h200);
        clear_caps();
        run_pass();
        chk(irq_n == 16 && eof_n == 16, "R10 sixteen per pass", irq_n, 16);
        chk(mem[(32'h100 + 8*16) >> 2] == 32'hE040_0001, "R10 rest untouched", mem[(32'h100 + 8*16) >> 2], 32'hE040_0001);
        run_pass();
        chk(irq_n == 20, "R10 resume", irq_n, 20);

        // flag clear: R11
        chk(tx_flag == 1, "R11 flag set", tx_flag, 1);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk(tx_flag == 0, "R11 flag cleared", tx_flag, 0);

        // byte cap: R12
        mode = 1'b1;
        put_desc(32'h100, 32'hE040_0258, 32'h400);
        set_ring(32'h100, 32'h200);
        clear_caps();
        run_pass();
        chk(cap_n == 2048, "R12 capped length", cap_n, 2048);
        chk(eof_n == 1 && cap[2047] == pat(32'h400 + 2047), "R12 last byte", cap[2047], pat(32'h400 + 2047));

        // ignored start: R13
        mode = 1'b0;
        put_desc(32'h100, 32'hE040_0001, 32'h400);
        set_ring(32'h100, 32'h200);
        chan_en = 1'b0;
        clear_caps();
        run_pass();
        chk(irq_n == 0 && cap_n == 0 && mem[32'h100 >> 2] == 32'hE040_0001, "R13 disabled channel",
            irq_n + cap_n, 0);
        chan_en = 1'b1;
        put_desc(32'h000, 32'hE040_0001, 32'h400);
        set_ring(32'h0, 32'h100);
        clear_caps();
        run_pass();
        chk(irq_n == 0 && mem[0] == 32'hE040_0001, "R13 zero ring start", irq_n, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule